// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block sits between a warp's load unit and the memory port. It takes one load request for a 32-lane warp. Each lane has an enable bit and the byte address of one 4-byte word. The block groups the enabled lanes by the aligned 128-byte segment their address falls in. For each distinct segment it issues one memory transaction, at most one per cycle, over a valid/ready request port. Every transaction carries the segment base address and a 32-bit mask of the lanes it serves. When the lanes in a warp use neighbouring words, this reduces up to 32 word reads to as few as one line read.

Lines come back in the order the transactions were issued. Up to a fixed number of transactions can be outstanding at once. For each returned line the block sends the correct 32-bit word to every lane in that transaction's mask. After every enabled lane has received its word, the block pulses a completion flag. It then accepts the next warp.

The control path is a four-state machine:
- **IDLE** accepts a warp. It moves to **ISSUE** if any lane is enabled, and straight to **DONE** if none is.
- **ISSUE** sends one segment per accepted handshake. It moves to **DRAIN** when the last segment is accepted.
- **DRAIN** waits until no transaction is outstanding, then moves to **DONE**.
- **DONE** raises the completion pulse for one cycle and returns to **IDLE**.

Top module: `warp_coalescer`

## Requirements
- R1: Every transaction address is a multiple of 128 (address bits [6:0] are zero). Its bits [31:7] equal bits [31:7] of the address of every lane in its mask.
- R2: A warp produces exactly as many transactions as there are distinct 128-byte segments among its enabled lanes, with no segment issued twice. Adjacent words in one segment give one transaction; 32 lanes in 32 different segments give 32 transactions.
- R3: Transactions leave in ascending order of the lowest enabled lane index that maps to each segment. Each mask holds every enabled lane of that segment and no other lane.
- R4: Lanes whose enable bit is 0 never appear in a transaction mask and never receive a lane data strobe.
- R5: A lane's word is bits [8*k+31 : 8*k] of the returned 1024-bit line, where k = 4 * address bits [6:2]. Byte 0 of the line is bits [7:0], and lane address bits [1:0] are ignored.
- R6: Lines return in issue order. The cycle after a line is accepted, lane_data_valid equals exactly that transaction's mask, with the routed words on lane_data. Each enabled lane is strobed exactly once per warp.
- R7: At most 4 transactions are outstanding, and new ones stop while 4 are outstanding. A request held without ready keeps its valid, address and mask unchanged. While segments remain and fewer than 4 are outstanding, the request valid is high.
- R8: done is high for exactly one cycle: the cycle after the final lane data strobe of the warp. For a warp with no lane enabled, it is the cycle after the warp is accepted, and no transaction is issued.
- R9: warp_ready is high only in IDLE. A new warp is taken only after the previous done pulse. After reset, warp_ready is 1 and mem_req_valid, done and lane_data_valid are 0.
- R10: Issuing a transaction and accepting a returned line in the same cycle are both handled, with no loss or duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_valid | input | 1 | Warp request present |
| warp_ready | output | 1 | Block can accept a warp (IDLE) |
| warp_active | input | 32 | Per-lane enable |
| warp_addr | input | 1024 | Lane i byte address at bits [32*i+31:32*i] |
| mem_req_valid | output | 1 | Transaction request valid |
| mem_req_ready | input | 1 | Memory accepts the transaction |
| mem_req_addr | output | 32 | 128-byte aligned segment base |
| mem_req_mask | output | 32 | Lanes served by this transaction |
| mem_rsp_valid | input | 1 | Returned line valid (issue order) |
| mem_rsp_line | input | 1024 | Returned 128-byte line |
| lane_data_valid | output | 32 | Per-lane strobe of returned word |
| lane_data | output | 1024 | Lane i word at bits [32*i+31:32*i] |
| done | output | 1 | One-cycle completion pulse |

## Verification
Issuing the next segment and routing a returned line can happen in the same cycle (R10). The bench provokes this overlap on purpose: it returns lines on a fixed cycle pattern that often coincides with an accepted request, and it withholds ready on another pattern. In one warp it also slows the returns enough that four transactions pile up. Each clock, a behavioural model compares the request address and mask against its own queue of expected segments. It predicts the next cycle's lane strobes from its own queue of outstanding masks, and checks the routed word against a line generator it computes independently. It predicts done from the set of lanes already served, so a lost or duplicated transaction shows up as a wrong strobe, a wrong count or a missing completion pulse.

// File: rtl/wc_pkg.sv
package wc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_DONE
    } wc_state_e;
endpackage

// File: rtl/wc_seg_picker.sv
// Finds the lowest pending lane and gathers every pending lane sharing its segment.
module wc_seg_picker #(
    parameter int LANES = 32,
    parameter int SEG_W = 25
) (
    input  logic [LANES-1:0]       pending,
    input  logic [LANES*SEG_W-1:0] lane_seg,
    output logic                   any_pending,
    output logic [SEG_W-1:0]       lead_seg,
    output logic [LANES-1:0]       group_mask
);
    always_comb begin
        lead_seg    = '0;
        any_pending = 1'b0;
        // descending scan: the lowest pending lane is written last and wins
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) begin
                lead_seg    = lane_seg[i*SEG_W +: SEG_W];
                any_pending = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_match
        assign group_mask[g] = pending[g] && (lane_seg[g*SEG_W +: SEG_W] == lead_seg);
    end
endmodule

// File: rtl/wc_mask_fifo.sv
// In-order record of the lane masks of outstanding transactions. DEPTH must be a power of two.
module wc_mask_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign head  = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                store[wr_ptr] <= push_data;
                wr_ptr        <= wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/wc_line_router.sv
// Registers the word each masked lane selects from an accepted line.
module wc_line_router #(
    parameter int LANES  = 32,
    parameter int WIDX_W = 5,
    parameter int WORD_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            fire,
    input  logic [LANES-1:0]                mask,
    input  logic [LANES*WIDX_W-1:0]         word_idx,
    input  logic [(WORD_W<<WIDX_W)-1:0]     line,
    output logic [LANES-1:0]                lane_valid,
    output logic [LANES*WORD_W-1:0]         lane_word
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_valid <= '0;
        end else begin
            lane_valid <= fire ? mask : '0;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [WIDX_W-1:0] idx;
        assign idx = word_idx[g*WIDX_W +: WIDX_W];
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_word[g*WORD_W +: WORD_W] <= '0;
            end else if (fire && mask[g]) begin
                lane_word[g*WORD_W +: WORD_W] <= line[int'(idx)*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import wc_pkg::*;
#(
    parameter int LANES     = 32,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128,
    parameter int WORD_W    = 32,
    parameter int OUTST     = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         warp_valid,
    output logic                         warp_ready,
    input  logic [LANES-1:0]             warp_active,
    input  logic [LANES*ADDR_W-1:0]      warp_addr,
    output logic                         mem_req_valid,
    input  logic                         mem_req_ready,
    output logic [ADDR_W-1:0]            mem_req_addr,
    output logic [LANES-1:0]             mem_req_mask,
    input  logic                         mem_rsp_valid,
    input  logic [SEG_BYTES*8-1:0]       mem_rsp_line,
    output logic [LANES-1:0]             lane_data_valid,
    output logic [LANES*WORD_W-1:0]      lane_data,
    output logic                         done
);
    localparam int OFF_W   = $clog2(SEG_BYTES);
    localparam int BYTE_W  = $clog2(WORD_W / 8);
    localparam int WIDX_W  = OFF_W - BYTE_W;
    localparam int SEG_W   = ADDR_W - OFF_W;
    localparam int CNT_W   = $clog2(OUTST + 1);

    wc_state_e state_q, state_d;

    logic [LANES-1:0]        active_q, pending_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES*SEG_W-1:0]  seg_flat;
    logic [LANES*WIDX_W-1:0] widx_flat;
    logic [LANES*BYTE_W-1:0] unused_lsb_flat;
    logic                    unused_lsb;

    logic                    pick_any;
    logic [SEG_W-1:0]        pick_seg;
    logic [LANES-1:0]        pick_mask;

    logic                    accept, issue_fire, rsp_fire, last_issue;
    logic [LANES-1:0]        fifo_head;
    logic [CNT_W-1:0]        fifo_count;
    logic                    fifo_full, fifo_empty;

    // split each lane address into segment, word index and ignored byte bits
    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign seg_flat[g*SEG_W +: SEG_W]          = addr_q[g*ADDR_W + OFF_W +: SEG_W];
        assign widx_flat[g*WIDX_W +: WIDX_W]       = addr_q[g*ADDR_W + BYTE_W +: WIDX_W];
        assign unused_lsb_flat[g*BYTE_W +: BYTE_W] = addr_q[g*ADDR_W +: BYTE_W];
    end
    assign unused_lsb = ^{unused_lsb_flat, pick_any};

    wc_seg_picker #(.LANES(LANES), .SEG_W(SEG_W)) u_picker (
        .pending     (pending_q),
        .lane_seg    (seg_flat),
        .any_pending (pick_any),
        .lead_seg    (pick_seg),
        .group_mask  (pick_mask)
    );

    wc_mask_fifo #(.W(LANES), .DEPTH(OUTST)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (issue_fire),
        .push_data (pick_mask),
        .pop       (rsp_fire),
        .head      (fifo_head),
        .count     (fifo_count),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    wc_line_router #(.LANES(LANES), .WIDX_W(WIDX_W), .WORD_W(WORD_W)) u_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (rsp_fire),
        .mask       (fifo_head),
        .word_idx   (widx_flat),
        .line       (mem_rsp_line),
        .lane_valid (lane_data_valid),
        .lane_word  (lane_data)
    );

    assign accept     = warp_valid && warp_ready;
    assign issue_fire = mem_req_valid && mem_req_ready;
    assign rsp_fire   = mem_rsp_valid && !fifo_empty;
    assign last_issue = ((pending_q & ~pick_mask) == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (warp_valid) state_d = (warp_active == '0) ? ST_DONE : ST_ISSUE;
            ST_ISSUE: if (issue_fire && last_issue) state_d = ST_DRAIN;
            ST_DRAIN: if (fifo_count == '0) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        warp_ready    = 1'b0;
        mem_req_valid = 1'b0;
        done          = 1'b0;
        unique case (state_q)
            ST_IDLE:  warp_ready    = 1'b1;
            ST_ISSUE: mem_req_valid = !fifo_full;
            ST_DRAIN: ;
            ST_DONE:  done          = 1'b1;
            default:  ;
        endcase
    end

    assign mem_req_addr = {pick_seg, {OFF_W{1'b0}}};
    assign mem_req_mask = pick_mask;

    // warp context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= '0;
            pending_q <= '0;
            addr_q    <= '0;
        end else if (accept) begin
            active_q  <= warp_active;
            pending_q <= warp_active;
            addr_q    <= warp_addr;
        end else if (issue_fire) begin
            pending_q <= pending_q & ~pick_mask;
        end
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_mask)));
    p_mask_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ((mem_req_mask != '0) && ((mem_req_mask & ~active_q) == '0)));
    p_strobe_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_data_valid & ~active_q) == '0));
    p_done_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((pending_q == '0) && fifo_empty && (lane_data_valid == '0)));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        warp_ready |-> (fifo_empty && !mem_req_valid));
endmodule

// File: tb/warp_coalescer_bench.sv
`timescale 1ns/1ps
module warp_coalescer_bench;
    localparam int L = 32;
    localparam int DEPTH = 4;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic warp_valid = 1'b0;
    logic warp_ready;
    logic [L-1:0] warp_active = '0;
    logic [L*32-1:0] warp_addr = '0;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic [L-1:0] mem_req_mask;
    logic mem_rsp_valid = 1'b0;
    logic [1023:0] mem_rsp_line = '0;
    logic [L-1:0] lane_data_valid;
    logic [L*32-1:0] lane_data;
    logic done;

    always #2 clk = ~clk;

    warp_coalescer u_warp_coalescer (
        .clk(clk), .rst_n(rst_n),
        .warp_valid(warp_valid), .warp_ready(warp_ready),
        .warp_active(warp_active), .warp_addr(warp_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_mask(mem_req_mask),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line),
        .lane_data_valid(lane_data_valid), .lane_data(lane_data),
        .done(done)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // warp description, written only by the initial block
    logic [L-1:0] w_act;
    logic [31:0]  w_addr [L];
    bit           slow_rsp = 1'b0;
    int           warp_req = 0;

    // model state, written only by the negedge process
    int           warp_acc = 0;
    int           warp_done = 0;
    bit           busy = 1'b0;
    bit           reset_seen = 1'b0;
    logic [L-1:0] cur_act, served, exp_lv, taken;
    logic [31:0]  cur_addr [L];
    logic [31:0]  exp_seg_q [$];
    logic [L-1:0] exp_mask_q [$];
    logic [31:0]  out_seg_q [$];
    logic [L-1:0] out_mask_q [$];
    int           issued, nseg;
    bit           exp_done;

    function automatic logic [31:0] word_of(input logic [31:0] seg, input int w);
        logic [31:0] v;
        v = (seg * 32 + w) * 32'h9E3779B1;
        return v ^ 32'hA5A50F0F;
    endfunction

    function automatic logic [1023:0] make_line(input logic [31:0] seg);
        logic [1023:0] ln;
        for (int w = 0; w < 32; w++) ln[w*32 +: 32] = word_of(seg, w);
        return ln;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        bit           rv, rdy, nxt_done;
        logic [L-1:0] nxt_lv;
        logic [31:0]  s, m;
        cyc++;
        if (cyc > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
        if (rst_n) begin
            if (!reset_seen) begin
                reset_seen = 1'b1;
                chk(warp_ready == 1'b1, "R9 reset warp_ready", 64'(warp_ready), 1);
                chk(mem_req_valid == 1'b0, "R9 reset mem_req_valid", 64'(mem_req_valid), 0);
                chk(done == 1'b0, "R9 reset done", 64'(done), 0);
                chk(lane_data_valid == '0, "R9 reset lane_data_valid", 64'(lane_data_valid), 0);
                exp_lv = '0;
                exp_done = 1'b0;
            end
            // lane strobes and routed words (R4, R5, R6)
            chk(lane_data_valid == exp_lv, "R6 lane strobe mask", 64'(lane_data_valid), 64'(exp_lv));
            for (int i = 0; i < L; i++) begin
                if (lane_data_valid[i] && exp_lv[i]) begin
                    chk(lane_data[i*32 +: 32] == word_of(cur_addr[i] >> 7, int'((cur_addr[i] >> 2) & 31)),
                        "R5 lane word", 64'(lane_data[i*32 +: 32]),
                        64'(word_of(cur_addr[i] >> 7, int'((cur_addr[i] >> 2) & 31))));
                    chk(!served[i], "R6 lane served once", 64'(served), 64'(cur_act));
                end
            end
            served = served | (lane_data_valid & exp_lv);
            nxt_done = 1'b0;
            if (busy && (lane_data_valid != '0) && (served == cur_act)) nxt_done = 1'b1;
            // completion (R8, R2)
            chk(done == exp_done, "R8 done pulse", 64'(done), 64'(exp_done));
            if (done && busy) begin
                chk(issued == nseg, "R2 transaction count", 64'(issued), 64'(nseg));
                busy = 1'b0;
                warp_done++;
            end
            // R9: no acceptance while a warp is in flight
            if (busy) chk(warp_ready == 1'b0, "R9 ready while busy", 64'(warp_ready), 0);
            // transaction port (R1, R3, R4, R7)
            if (mem_req_valid) begin
                chk(exp_seg_q.size() > 0, "R2 unexpected transaction", 64'(mem_req_addr), 0);
                if (exp_seg_q.size() > 0) begin
                    chk(mem_req_addr == exp_seg_q[0], "R1 R3 segment address", 64'(mem_req_addr), 64'(exp_seg_q[0]));
                    chk(mem_req_mask == exp_mask_q[0], "R3 R4 lane mask", 64'(mem_req_mask), 64'(exp_mask_q[0]));
                end
                chk(out_seg_q.size() < DEPTH, "R7 outstanding limit", 64'(out_seg_q.size()), DEPTH);
            end else if (busy && exp_seg_q.size() > 0 && out_seg_q.size() < DEPTH) begin
                chk(1'b0, "R7 request valid expected", 0, 1);
            end
            // return path: oldest outstanding first (R6, R10)
            rv = (out_seg_q.size() > 0) && (slow_rsp ? (cyc % 9 == 0) : (cyc % 3 != 1));
            nxt_lv = '0;
            mem_rsp_valid = rv;
            if (rv) begin
                s = out_seg_q.pop_front();
                nxt_lv = out_mask_q.pop_front();
                mem_rsp_line = make_line(s >> 7);
            end
            rdy = (cyc % 5 != 3);
            mem_req_ready = rdy;
            if (mem_req_valid && rdy && exp_seg_q.size() > 0) begin
                out_seg_q.push_back(exp_seg_q.pop_front());
                out_mask_q.push_back(exp_mask_q.pop_front());
                issued++;
            end
            // warp port
            if (!busy && warp_acc < warp_req) begin
                warp_valid = 1'b1;
                warp_active = w_act;
                for (int i = 0; i < L; i++) warp_addr[i*32 +: 32] = w_addr[i];
                if (warp_ready) begin
                    busy = 1'b1;
                    warp_acc++;
                    cur_act = w_act;
                    for (int i = 0; i < L; i++) cur_addr[i] = w_addr[i];
                    served = '0;
                    issued = 0;
                    taken = '0;
                    exp_seg_q.delete();
                    exp_mask_q.delete();
                    for (int i = 0; i < L; i++) begin
                        if (cur_act[i] && !taken[i]) begin
                            m = '0;
                            for (int j = 0; j < L; j++)
                                if (cur_act[j] && ((cur_addr[j] >> 7) == (cur_addr[i] >> 7))) m[j] = 1'b1;
                            taken = taken | m;
                            exp_seg_q.push_back((cur_addr[i] >> 7) << 7);
                            exp_mask_q.push_back(m);
                        end
                    end
                    nseg = exp_seg_q.size();
                    if (cur_act == '0) nxt_done = 1'b1;
                end
            end else if (busy) begin
                warp_valid = 1'b1;          // held high: must not be taken (R9)
                warp_active = ~w_act;
            end else begin
                warp_valid = 1'b0;
            end
            exp_lv = nxt_lv;
            exp_done = nxt_done;
        end
    end

    task automatic run_warp(input logic [L-1:0] act, input bit slow);
        w_act = act;
        slow_rsp = slow;
        warp_req++;
        while (warp_done < warp_req) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R2: adjacent words in one segment -> one transaction
        for (int i = 0; i < L; i++) w_addr[i] = 32'h4000 + 4 * i;
        run_warp('1, 1'b0);
        // R2 R7 R10: every lane in its own segment, slow returns fill the outstanding limit
        for (int i = 0; i < L; i++) w_addr[i] = 32'h10000 + 128 * i + 4 * ((i * 7) % 32);
        run_warp('1, 1'b1);
        // R2: stride of 16 words -> two lanes per segment
        for (int i = 0; i < L; i++) w_addr[i] = 32'h20000 + 64 * i;
        run_warp('1, 1'b0);
        // R3 R4: partial enables, segments in descending address order by lane
        for (int i = 0; i < L; i++) w_addr[i] = 32'h8000 + 128 * ((31 - i) % 4) + 4 * ((i * 7) % 32);
        run_warp(32'hA5A5_3C3C, 1'b0);
        // R8: no lane enabled
        run_warp('0, 1'b0);
        // R5: scattered segments with nonzero low address bits
        for (int i = 0; i < L; i++) w_addr[i] = 32'h3000 + 128 * ((i * 13) % 7) + 4 * ((i * 5) % 32) + (i % 4);
        run_warp(32'hFFFF_7FFE, 1'b0);
        // R4: a single enabled lane
        run_warp(32'h0000_8000, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule